// File: doc/BRIEF.md
# Dual-Thread Shared Macro-Op Decoder

This block is the decode-stage allocator of a core in which two hardware threads share one instruction decoder. Each thread pushes pre-classified instruction descriptors into its own small buffer. A descriptor replaces the instruction bytes and carries the decode class, the macro-op count, the number of prefixes and two flags that mark a compare/test and a conditional jump. Each cycle the decoder picks one thread and presents one beat of up to two macro-ops, tagged with the thread number, on a valid/ready output.

The block models the decode limits of the shared decoder. The threads take turns. A cycle holds either two one-macro-op instructions or one two-macro-op instruction. A compare/test and the conditional jump behind it fuse into a single macro-op. A microcoded instruction keeps the decoder busy for several cycles. An instruction with a long prefix chain costs extra cycles. While one thread holds the decoder, the other thread waits.

Top module: `dual_decode`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and both `t0_ready` and `t1_ready` are 1. The first thread to be offered the decoder is thread 0.
- R2: A descriptor is 12 bits: [11:10] class (0 single, 1 double, 2 microcoded, 3 handled as single), [9:6] macro-op count, [5:2] prefix count, [1] compare/test flag, [0] conditional-jump flag. Each thread's buffer holds DEPTH (4) descriptors. When a buffer is full, its ready is 0 and a descriptor offered to it is dropped.
- R3: After each accepted beat the turn passes to the other thread. `out_tid` names the thread the beat came from.
- R4: When the thread whose turn it is has an empty buffer and the other thread has work, the other thread is served in that same cycle.
- R5: A beat carries 1 or 2 macro-ops (`out_cnt`). Two singles back to back in one thread's buffer go out together with `out_cnt` 2. A double goes out alone with `out_cnt` 2. A single followed by a double, by a microcoded instruction, by an instruction with 4 or more prefixes, or by nothing goes out alone with `out_cnt` 1.
- R6: A single with the compare/test flag, followed in the same buffer by a single with the conditional-jump flag, consumes both descriptors in one beat with `out_cnt` 1 and `out_fused` 1.
- R7: Fusion applies only to the two instructions taken in the same cycle. A compare/test that goes out as the second of a pair, or that goes out alone, is not fused with a later jump.
- R8: A microcoded instruction with M macro-ops takes ceil(M/2) consecutive beats of one thread. Every beat has `out_cnt` 2 except the last beat of an odd M, which has 1. The other thread gets no beat until the last one is accepted.
- R9: A head instruction with 4 to 7 prefixes causes STALL_MID (15) cycles with `out_valid` 0 before its first beat.
- R10: A head instruction with 8 or more prefixes causes STALL_LONG (21) cycles with `out_valid` 0 before its first beat.
- R11: During a prefix stall or a microcode sequence of one thread, the other thread gets no beat, even if it has work.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_tid` stays the same and no descriptor leaves either buffer. The beat may still grow if a pairing partner arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| t0_valid | input | 1 | Thread 0 offers a descriptor |
| t0_desc | input | 12 | Thread 0 descriptor |
| t0_ready | output | 1 | Thread 0 buffer has room |
| t1_valid | input | 1 | Thread 1 offers a descriptor |
| t1_desc | input | 12 | Thread 1 descriptor |
| t1_ready | output | 1 | Thread 1 buffer has room |
| out_valid | output | 1 | A decode beat is presented |
| out_ready | input | 1 | Downstream accepts the beat |
| out_tid | output | 1 | Thread of the beat |
| out_cnt | output | 2 | Macro-ops in the beat (1 or 2) |
| out_fused | output | 1 | Beat is a fused compare and jump |

## Verification
The bench goes after the places where the pairing window and the stall logic are easy to get wrong. It checks that a compare which goes out as the second of a pair does not fuse with the jump behind it; a decoder that looks one instruction too far would merge them and lose a macro-op. It also checks that a single followed by a double goes out alone, and that an odd-length microcode sequence ends on a one-macro-op beat; a wrong ceiling would emit a phantom macro-op or drop one. It counts the exact number of dead cycles for both prefix bands while the other thread has work pending, so an off-by-one stall counter or a decoder that lets the idle thread slip in shows up directly. Backpressure tests confirm that the thread tag stays put and that no descriptor is lost while the downstream stage waits.

// File: rtl/dd_pkg.sv
// Shared types for the dual-thread decoder: descriptor layout, class
// codes and decoder states. Field order in desc_t fixes the bit layout
// that the producers of descriptors use.
package dd_pkg;
    localparam int MOP_W = 4;
    localparam int PFX_W = 4;

    typedef enum logic [1:0] {
        CLS_SINGLE = 2'd0,
        CLS_DOUBLE = 2'd1,
        CLS_UCODE  = 2'd2,
        CLS_RSVD   = 2'd3
    } cls_e;

    typedef struct packed {
        cls_e             cls;
        logic [MOP_W-1:0] mops;
        logic [PFX_W-1:0] pfx;
        logic             is_cmp;
        logic             is_jcc;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PFX   = 2'd1,
        ST_UCODE = 2'd2
    } st_e;
endpackage

// File: rtl/desc_fifo.sv
// Per-thread descriptor buffer. It shows the two oldest entries and
// can pop zero, one or two per cycle.
// Assumes: DEPTH is a power of two and at least 2; the caller never pushes
// when full and never pops more than the fill level.
module desc_fifo
    import dd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  desc_t                        push_data,
    input  logic [1:0]                   pop_n,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output desc_t                        head,
    output desc_t                        next
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    desc_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    // Store an incoming descriptor at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            count  <= count + CNT_W'(push) - CNT_W'(pop_n);
        end
    end

    assign full = (count == CNT_W'(DEPTH));
    assign fill = count;
    assign head = mem[rd_ptr];
    assign next = mem[rd_ptr + PTR_W'(1)];

    // R2
    fifo_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_n) <= count);
endmodule

// File: rtl/thread_pick.sv
// Picks which thread owns the decoder this cycle. A lock keeps the owner
// fixed during stalls, microcode sequences and held beats. Otherwise the
// turn holder is chosen, or the other thread if the turn holder is empty.
// Assumes: exactly two threads.
module thread_pick (
    input  logic       turn,
    input  logic [1:0] has_work,
    input  logic       lock_en,
    input  logic       lock_tid,
    output logic       sel,
    output logic       any
);
    // Choose the owner of the decoder for this cycle.
    always_comb begin
        if (lock_en) begin
            sel = lock_tid;
            any = 1'b1;
        end else begin
            sel = has_work[turn] ? turn : ~turn;
            any = |has_work;
        end
    end
endmodule

// File: rtl/decode_core.sv
// Shared decode engine. From the selected thread's two oldest descriptors
// it forms one beat: a pair of singles, a fused compare and jump, a
// double, or a step of a microcode sequence. It also runs the prefix
// stall counter and the turn and lock state.
// Assumes: STALL_MID and STALL_LONG are at least 2; head and next belong to
// the thread given by sel.
module decode_core
    import dd_pkg::*;
#(
    parameter int FILL_W     = 3,
    parameter int STALL_MID  = 15,
    parameter int STALL_LONG = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic              sel,
    input  desc_t             head,
    input  desc_t             next,
    input  logic [FILL_W-1:0] fill,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [1:0]        out_cnt,
    output logic              out_fused,
    output logic [1:0]        pop_n,
    output logic              lock_en,
    output logic              lock_tid,
    output logic              turn
);
    localparam int PC_W = $clog2(STALL_LONG);
    localparam logic [PC_W-1:0] LOAD_MID  = PC_W'(STALL_MID - 2);
    localparam logic [PC_W-1:0] LOAD_LONG = PC_W'(STALL_LONG - 2);

    st_e              state;
    logic [PC_W-1:0]  pcnt;
    logic [MOP_W-1:0] left;
    logic             pfx_done;
    logic             hold_q;
    logic             lock_q;
    logic             turn_q;
    logic             long_pfx;
    logic             pair_ok;
    logic             accept;
    logic [1:0]       beat_pop;
    logic             unused_fields;

    assign unused_fields = ^{next.mops, next.is_cmp, head.is_jcc};

    assign long_pfx = (head.pfx >= PFX_W'(4)) && !pfx_done;
    assign pair_ok  = (fill > FILL_W'(1)) && (next.cls != CLS_DOUBLE) &&
                      (next.cls != CLS_UCODE) && (next.pfx < PFX_W'(4));
    assign accept   = out_valid && out_ready;
    assign pop_n    = accept ? beat_pop : 2'd0;
    assign lock_en  = (state != ST_IDLE) || pfx_done || hold_q;
    assign lock_tid = lock_q;
    assign turn     = turn_q;

    // Form the beat offered this cycle and how many descriptors it uses.
    always_comb begin
        out_valid = 1'b0;
        out_cnt   = 2'd0;
        out_fused = 1'b0;
        beat_pop  = 2'd0;
        case (state)
            ST_IDLE: begin
                if (any && !long_pfx) begin
                    out_valid = 1'b1;
                    if (head.cls == CLS_UCODE) begin
                        if (head.mops > MOP_W'(2)) begin
                            out_cnt = 2'd2;
                        end else begin
                            out_cnt  = (head.mops == MOP_W'(2)) ? 2'd2 : 2'd1;
                            beat_pop = 2'd1;
                        end
                    end else if (head.cls == CLS_DOUBLE) begin
                        out_cnt  = 2'd2;
                        beat_pop = 2'd1;
                    end else if (pair_ok && head.is_cmp && next.is_jcc) begin
                        out_cnt   = 2'd1;
                        out_fused = 1'b1;
                        beat_pop  = 2'd2;
                    end else if (pair_ok) begin
                        out_cnt  = 2'd2;
                        beat_pop = 2'd2;
                    end else begin
                        out_cnt  = 2'd1;
                        beat_pop = 2'd1;
                    end
                end
            end
            ST_UCODE: begin
                out_valid = 1'b1;
                out_cnt   = (left >= MOP_W'(2)) ? 2'd2 : 2'd1;
                beat_pop  = (left <= MOP_W'(2)) ? 2'd1 : 2'd0;
            end
            default: ;
        endcase
    end

    // Advance the stall, microcode, turn and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pcnt     <= '0;
            left     <= '0;
            pfx_done <= 1'b0;
            hold_q   <= 1'b0;
            lock_q   <= 1'b0;
            turn_q   <= 1'b0;
        end else begin
            hold_q <= out_valid && !out_ready;
            if (out_valid && !out_ready) lock_q <= sel;
            if (accept) begin
                turn_q   <= ~sel;
                pfx_done <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (any && long_pfx) begin
                        state  <= ST_PFX;
                        pcnt   <= (head.pfx >= PFX_W'(8)) ? LOAD_LONG : LOAD_MID;
                        lock_q <= sel;
                    end else if (accept && head.cls == CLS_UCODE &&
                                 head.mops > MOP_W'(2)) begin
                        state  <= ST_UCODE;
                        left   <= head.mops - MOP_W'(2);
                        lock_q <= sel;
                    end
                end
                ST_PFX: begin
                    if (pcnt == '0) begin
                        state    <= ST_IDLE;
                        pfx_done <= 1'b1;
                    end else begin
                        pcnt <= pcnt - PC_W'(1);
                    end
                end
                ST_UCODE: begin
                    if (accept) begin
                        if (left <= MOP_W'(2)) state <= ST_IDLE;
                        else left <= left - MOP_W'(2);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R12
    held_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(sel));

    // R8
    ucode_cont_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && beat_pop == 2'd0 |=> out_valid && $stable(sel));

    // R11
    pfx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_PFX && pcnt != '0 |=> !out_valid);

    // R5
    beat_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cnt == 2'd1 || out_cnt == 2'd2));
endmodule

// File: rtl/dual_decode.sv
// Top of the dual-thread shared decoder: two descriptor buffers (one per
// thread), the thread picker and the shared decode engine. One beat of up
// to two macro-ops goes out per cycle on a valid/ready output.
// Assumes: descriptors follow dd_pkg::desc_t; DEPTH is a power of two >= 2.
module dual_decode
    import dd_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int STALL_MID  = 15,
    parameter int STALL_LONG = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              t0_valid,
    input  logic [DESC_W-1:0] t0_desc,
    output logic              t0_ready,
    input  logic              t1_valid,
    input  logic [DESC_W-1:0] t1_desc,
    output logic              t1_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_tid,
    output logic [1:0]        out_cnt,
    output logic              out_fused
);
    localparam int NTHR  = 2;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NTHR-1:0]  push_v;
    logic [NTHR-1:0]  full;
    logic [NTHR-1:0]  has_work;
    desc_t            push_d [NTHR];
    desc_t            head_d [NTHR];
    desc_t            next_d [NTHR];
    logic [CNT_W-1:0] fill   [NTHR];
    logic [1:0]       pop_n  [NTHR];
    logic [1:0]       core_pop;
    logic             sel;
    logic             any;
    logic             lock_en;
    logic             lock_tid;
    logic             turn;

    assign push_v    = {t1_valid, t0_valid};
    assign push_d[0] = desc_t'(t0_desc);
    assign push_d[1] = desc_t'(t1_desc);
    assign t0_ready  = !full[0];
    assign t1_ready  = !full[1];
    assign out_tid   = sel;

    for (genvar g = 0; g < NTHR; g++) begin : g_thr
        desc_fifo #(.DEPTH(DEPTH)) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_v[g] && !full[g]),
            .push_data (push_d[g]),
            .pop_n     (pop_n[g]),
            .full      (full[g]),
            .fill      (fill[g]),
            .head      (head_d[g]),
            .next      (next_d[g])
        );
        assign pop_n[g]    = (sel == 1'(g)) ? core_pop : 2'd0;
        assign has_work[g] = (fill[g] != '0);
    end

    thread_pick u_pick (
        .turn     (turn),
        .has_work (has_work),
        .lock_en  (lock_en),
        .lock_tid (lock_tid),
        .sel      (sel),
        .any      (any)
    );

    decode_core #(
        .FILL_W     (CNT_W),
        .STALL_MID  (STALL_MID),
        .STALL_LONG (STALL_LONG)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .any       (any),
        .sel       (sel),
        .head      (head_d[sel]),
        .next      (next_d[sel]),
        .fill      (fill[sel]),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_cnt   (out_cnt),
        .out_fused (out_fused),
        .pop_n     (core_pop),
        .lock_en   (lock_en),
        .lock_tid  (lock_tid),
        .turn      (turn)
    );

    // R12
    pop_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n[0] != 2'd0 || pop_n[1] != 2'd0) |-> out_valid && out_ready);
endmodule

// File: tb/dual_decode_test.sv
`timescale 1ns/1ps
module dual_decode_test;
    import dd_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              t0_valid = 1'b0, t1_valid = 1'b0;
    logic [DESC_W-1:0] t0_desc = '0, t1_desc = '0;
    logic              t0_ready, t1_ready;
    logic              out_valid, out_tid, out_fused;
    logic              out_ready = 1'b0;
    logic [1:0]        out_cnt;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_decode uut (
        .clk(clk), .rst_n(rst_n),
        .t0_valid(t0_valid), .t0_desc(t0_desc), .t0_ready(t0_ready),
        .t1_valid(t1_valid), .t1_desc(t1_desc), .t1_ready(t1_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_tid(out_tid),
        .out_cnt(out_cnt), .out_fused(out_fused)
    );

    // Descriptor codes per R2: {class, mops, prefixes, cmp, jcc}
    localparam logic [11:0] D_S   = {2'd0, 4'd1, 4'd0, 1'b0, 1'b0};
    localparam logic [11:0] D_D   = {2'd1, 4'd2, 4'd0, 1'b0, 1'b0};
    localparam logic [11:0] D_CMP = {2'd0, 4'd1, 4'd1, 1'b1, 1'b0};
    localparam logic [11:0] D_JCC = {2'd0, 4'd1, 4'd0, 1'b0, 1'b1};
    localparam logic [11:0] D_U5  = {2'd2, 4'd5, 4'd0, 1'b0, 1'b0};
    localparam logic [11:0] D_U4  = {2'd2, 4'd4, 4'd0, 1'b0, 1'b0};
    localparam logic [11:0] D_P5  = {2'd0, 4'd1, 4'd5, 1'b0, 1'b0};
    localparam logic [11:0] D_P9  = {2'd0, 4'd1, 4'd9, 1'b0, 1'b0};

    // Stimulus: {scenario, thread, descriptor}, pushed in order with output stalled
    localparam int NSTIM = 24;
    localparam logic [16:0] STIM [NSTIM] = '{
        {4'd0, 1'b0, D_D}, {4'd0, 1'b0, D_D}, {4'd0, 1'b1, D_D}, {4'd0, 1'b1, D_D},
        {4'd1, 1'b0, D_S}, {4'd1, 1'b0, D_S}, {4'd1, 1'b0, D_S},
        {4'd2, 1'b0, D_CMP}, {4'd2, 1'b0, D_JCC}, {4'd2, 1'b0, D_S},
        {4'd3, 1'b0, D_S}, {4'd3, 1'b0, D_CMP}, {4'd3, 1'b0, D_JCC},
        {4'd4, 1'b0, D_U5}, {4'd4, 1'b1, D_S},
        {4'd5, 1'b1, D_D}, {4'd5, 1'b1, D_S},
        {4'd6, 1'b0, D_CMP}, {4'd6, 1'b0, D_D},
        {4'd7, 1'b0, D_S}, {4'd7, 1'b1, D_U4},
        {4'd8, 1'b0, D_S}, {4'd8, 1'b0, D_D}, {4'd8, 1'b0, D_S}
    };
    // Expected beats: {scenario, tid, cnt, fused}
    localparam int NEXP = 24;
    localparam logic [7:0] EXPB [NEXP] = '{
        {4'd0, 1'b0, 2'd2, 1'b0}, {4'd0, 1'b1, 2'd2, 1'b0},   // R3
        {4'd0, 1'b0, 2'd2, 1'b0}, {4'd0, 1'b1, 2'd2, 1'b0},
        {4'd1, 1'b0, 2'd2, 1'b0}, {4'd1, 1'b0, 2'd1, 1'b0},   // R5
        {4'd2, 1'b0, 2'd1, 1'b1}, {4'd2, 1'b0, 2'd1, 1'b0},   // R6
        {4'd3, 1'b0, 2'd2, 1'b0}, {4'd3, 1'b0, 2'd1, 1'b0},   // R7
        {4'd4, 1'b0, 2'd2, 1'b0}, {4'd4, 1'b0, 2'd2, 1'b0},   // R8 odd
        {4'd4, 1'b0, 2'd1, 1'b0}, {4'd4, 1'b1, 2'd1, 1'b0},
        {4'd5, 1'b1, 2'd2, 1'b0}, {4'd5, 1'b1, 2'd1, 1'b0},   // R4
        {4'd6, 1'b0, 2'd1, 1'b0}, {4'd6, 1'b0, 2'd2, 1'b0},   // R7 cmp alone
        {4'd7, 1'b0, 2'd1, 1'b0}, {4'd7, 1'b1, 2'd2, 1'b0},   // R8 even
        {4'd7, 1'b1, 2'd2, 1'b0},
        {4'd8, 1'b0, 2'd1, 1'b0}, {4'd8, 1'b0, 2'd2, 1'b0},   // R5 single then double
        {4'd8, 1'b0, 2'd1, 1'b0}
    };
    localparam string SCN_REQ [9] = '{"R3", "R5", "R6", "R7", "R8", "R4", "R7", "R8", "R5"};

    logic [3:0] obs [16];
    int         nobs;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        t0_valid = 1'b0; t1_valid = 1'b0; out_ready = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic push(input logic thr, input logic [11:0] d);
        if (thr) begin t1_valid = 1'b1; t1_desc = d; end
        else     begin t0_valid = 1'b1; t0_desc = d; end
        @(posedge clk); #1;
        t0_valid = 1'b0; t1_valid = 1'b0;
    endtask

    // Record accepted beats {tid, cnt, fused} over a number of cycles
    task automatic collect(input int ncyc);
        nobs = 0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (out_valid && out_ready && nobs < 16) begin
                obs[nobs] = {out_tid, out_cnt, out_fused};
                nobs++;
            end
            @(posedge clk); #1;
        end
    endtask

    // Prefix stall run: returns dead cycles, first and second beat threads
    task automatic pfx_run(input logic [11:0] d, output int dead,
                           output int tid_a, output int tid_b);
        do_reset();
        out_ready = 1'b1;
        t0_valid = 1'b1; t0_desc = d;
        t1_valid = 1'b1; t1_desc = D_S;
        @(posedge clk); #1;
        t0_valid = 1'b0; t1_valid = 1'b0;
        dead = 0; tid_a = -1; tid_b = -1;
        for (int c = 0; c < 60; c++) begin
            @(negedge clk);
            if (out_valid) begin
                if (tid_a < 0) tid_a = int'(out_tid);
                else if (tid_b < 0) tid_b = int'(out_tid);
            end else if (tid_a < 0) begin
                dead++;
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int dead, ta, tb;

        // R1: reset state
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 t0_ready in reset", int'(t0_ready), 1);
        chk("R1 t1_ready in reset", int'(t1_ready), 1);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        @(posedge clk); #1;

        // Table walk: one scenario per reset
        for (int s = 0; s < 9; s++) begin
            int k;
            do_reset();
            for (int i = 0; i < NSTIM; i++)
                if (int'(STIM[i][16:13]) == s) push(STIM[i][12], STIM[i][11:0]);
            out_ready = 1'b1;
            collect(12);
            k = 0;
            for (int i = 0; i < NEXP; i++) begin
                if (int'(EXPB[i][7:4]) == s) begin
                    if (k < nobs) chk(SCN_REQ[s], int'(obs[k]), int'(EXPB[i][3:0]));
                    k++;
                end
            end
            chk({SCN_REQ[s], " beat count"}, nobs, k);
        end

        // R2: buffer full drops a fifth descriptor
        do_reset();
        for (int i = 0; i < 4; i++) push(1'b0, D_D);
        @(negedge clk);
        chk("R2 t0_ready when full", int'(t0_ready), 0);
        chk("R2 t1_ready other thread", int'(t1_ready), 1);
        @(posedge clk); #1;
        push(1'b0, D_S);
        out_ready = 1'b1;
        collect(10);
        chk("R2 beats after overflow", nobs, 4);
        chk("R2 last beat is double", int'(obs[3][2:1]), 2);

        // R12: held beat keeps its thread and loses nothing
        do_reset();
        push(1'b0, D_S);
        push(1'b1, D_D);
        push(1'b0, D_S);
        @(negedge clk);
        chk("R12 held valid", int'(out_valid), 1);
        chk("R12 held tid", int'(out_tid), 0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        collect(6);
        chk("R12 beats after release", nobs, 2);
        chk("R12 first beat", int'(obs[0]), int'({1'b0, 2'd2, 1'b0}));
        chk("R12 second beat", int'(obs[1]), int'({1'b1, 2'd2, 1'b0}));

        // R9 and R11: mid prefix band with other thread waiting
        pfx_run(D_P5, dead, ta, tb);
        chk("R9 dead cycles", dead, 15);
        chk("R11 first beat thread", ta, 0);
        chk("R11 second beat thread", tb, 1);

        // R10 and R11: long prefix band
        pfx_run(D_P9, dead, ta, tb);
        chk("R10 dead cycles", dead, 21);
        chk("R11 long first beat thread", ta, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule